// File: doc/BRIEF.md
# Load/Store Multiple Word Sequencer

This block executes a block-move instruction that transfers a run of general-purpose registers to or from memory. It turns the move into single-word accesses, one per register. The run starts at a chosen register and always ends at register 31. The caller supplies the following with a one-cycle start pulse:

- the direction (load or store);
- the first register;
- the base register index and its value;
- a signed 16-bit displacement;
- the current byte-order mode.

The sequencer then works on its own. It issues word requests over a valid/ready memory port. It writes loaded words into the register file as the read data comes back. For stores, it reads each source register at the moment that register's request is presented.

A run of up to 32 words can reach into the next 4 KB page. Before the first word of the second page goes out, the sequencer asks an external translation unit to check that page, and it waits for the answer. If the check faults, no access is made to the second page. Any loads still in flight are allowed to return, and the sequencer then ends with a data-page exception. First-page registers that were already loaded keep their new values. Retrying the instruction means issuing a fresh start, and the new run begins again at the first register and the first address.

Some requests are refused before any memory traffic. Misaligned addresses and little-endian mode give an alignment exception. A load whose base register lies in its own destination range gives an invalid-form exception.

Top module: `lsm_seq`

## Requirements
- R1: The effective address (EA) is the base value plus the sign-extended displacement, computed modulo 2^32. A base index of 0 supplies zero instead of the base value. Register n (start ≤ n ≤ 31) is moved at EA + 4·(n − start), in ascending register order, with one word per accepted handshake. A load request has req_we = 0 and a store request has req_we = 1.
- R2: If EA[1:0] is not 00, the block ends with exc_cause = 1 (alignment). It makes no memory request and no translation request.
- R3: While le_mode = 1, every load or store ends with exc_cause = 1 (alignment) and makes no memory request.
- R4: A load with base_idx ≠ 0 and base_idx ≥ start_reg ends with exc_cause = 2 (invalid form) and makes no memory request. A store is never an invalid form. When both apply, the alignment cause wins.
- R5: Some word other than the first may have an address whose low 12 bits are zero. In that case, before issuing it, the block raises xlat_req with xlat_addr equal to that address, holds req_valid low until xlat_done, and continues if xlat_fault = 0. A transfer whose first word sits on a page start needs no check.
- R6: If xlat_fault = 1 at xlat_done, the block issues no second-page request. It waits for all outstanding load data, then ends with exc_cause = 3 (page fault). First-page loaded registers keep their new values and later registers are unchanged.
- R7: A start accepted after an exception runs from the first register and the first address again.
- R8: Loads write rf_wr_idx = start + (number of earlier responses) with the returned data, and only on rsp_valid. Stores drive rf_rd_idx with the current register and send its rf_rd_data as req_wdata. Stores never write the register file.
- R9: After reset, busy, done, exc, req_valid and xlat_req are low. busy is high from the cycle after an accepted start until the ending pulse. The run ends with exactly one single-cycle pulse, either done or exc, and exc_cause holds the cause during that pulse. A start while busy is ignored.
- R10: Once raised, req_valid stays high with stable address and direction until req_ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Start pulse, taken when idle |
| op_store | input | 1 | 1 = store multiple, 0 = load multiple |
| start_reg | input | 5 | First register of the run |
| base_idx | input | 5 | Base register index (0 = zero base) |
| base_val | input | 32 | Base register value |
| disp | input | 16 | Signed displacement |
| le_mode | input | 1 | Little-endian byte order selected |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle successful completion |
| exc | output | 1 | One-cycle exception pulse |
| exc_cause | output | 2 | 1 alignment, 2 invalid form, 3 page fault |
| req_valid | output | 1 | Memory word request valid |
| req_ready | input | 1 | Memory accepts request |
| req_we | output | 1 | Request is a write |
| req_addr | output | 32 | Word address |
| req_wdata | output | 32 | Store data |
| rsp_valid | input | 1 | Load data valid (in order) |
| rsp_rdata | input | 32 | Load data |
| rf_we | output | 1 | Register file write enable |
| rf_wr_idx | output | 5 | Register file write index |
| rf_wr_data | output | 32 | Register file write data |
| rf_rd_idx | output | 5 | Register file read index |
| rf_rd_data | input | 32 | Register file read data |
| xlat_req | output | 1 | Second-page check request |
| xlat_addr | output | 32 | Address of the page being checked |
| xlat_done | input | 1 | Check complete |
| xlat_fault | input | 1 | Check found a fault |

## Verification
The bench drives loads and stores through the following patterns, each of which isolates one behaviour:

- Runs that stay within one page separate correct address stepping and register indexing from the page-crossing logic.
- Runs that cross a page with a clean check show that the sequencer pauses for exactly one check at the right address.
- Runs that cross a page with a faulting check show that traffic stops at the page edge and that only the first-page registers change.
- A one-word run starting exactly on a page start confirms that no needless check is made.
- A zero base index and a displacement that wraps the address confirm that the base selection and sign extension are right.
- Rejected forms (misaligned, little-endian, base inside the load range, and a misaligned invalid form) check the cause codes and their priority, and show that no memory traffic occurs.
- A stalling memory port, a start pulse poked mid-run, and a retry after a fault test the handshake hold, the ignoring of a start while busy, and the restart from the first register.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'd0,
        CAUSE_ALIGN = 2'd1,
        CAUSE_FORM  = 2'd2,
        CAUSE_PAGE  = 2'd3
    } cause_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_ISSUE,
        S_XLAT,
        S_DRAIN
    } state_e;
endpackage

// File: rtl/lsm_ea_check.sv
module lsm_ea_check
    import lsm_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DISP_W    = 16,
    parameter int REG_W     = 5,
    parameter int LANE_BITS = 2
) (
    input  logic              op_store,
    input  logic [REG_W-1:0]  start_reg,
    input  logic [REG_W-1:0]  base_idx,
    input  logic [ADDR_W-1:0] base_val,
    input  logic [DISP_W-1:0] disp,
    input  logic              le_mode,
    output logic [ADDR_W-1:0] ea,
    output cause_e            cause
);
    logic [ADDR_W-1:0] base_sel;
    logic [ADDR_W-1:0] disp_ext;
    logic              misaligned;
    logic              bad_form;

    always_comb begin
        base_sel   = (base_idx == '0) ? '0 : base_val;
        disp_ext   = {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};
        ea         = base_sel + disp_ext;
        misaligned = (ea[LANE_BITS-1:0] != '0);
        bad_form   = !op_store && (base_idx != '0) && (base_idx >= start_reg);
        if (le_mode || misaligned) begin
            cause = CAUSE_ALIGN;
        end else if (bad_form) begin
            cause = CAUSE_FORM;
        end else begin
            cause = CAUSE_NONE;
        end
    end
endmodule

// File: rtl/lsm_rsp_track.sv
module lsm_rsp_track #(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             active,
    input  logic             is_load,
    input  logic [REG_W-1:0] first_reg,
    input  logic             rsp_valid,
    output logic             wr_en,
    output logic [REG_W-1:0] wr_idx
);
    logic [REG_W-1:0] cnt_d, cnt_q;

    always_comb begin
        wr_en  = rsp_valid && active && is_load;
        wr_idx = first_reg + cnt_q;
        cnt_d  = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (wr_en) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/lsm_seq.sv
module lsm_seq
    import lsm_pkg::*;
#(
    parameter int REG_N     = 32,
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int DISP_W    = 16,
    parameter int PAGE_BITS = 12,
    localparam int REG_W     = $clog2(REG_N),
    localparam int WORD_B    = DATA_W / 8,
    localparam int LANE_BITS = $clog2(WORD_B)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op_store,
    input  logic [REG_W-1:0]  start_reg,
    input  logic [REG_W-1:0]  base_idx,
    input  logic [ADDR_W-1:0] base_val,
    input  logic [DISP_W-1:0] disp,
    input  logic              le_mode,
    output logic              busy,
    output logic              done,
    output logic              exc,
    output logic [1:0]        exc_cause,
    output logic              req_valid,
    input  logic              req_ready,
    output logic              req_we,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_wdata,
    input  logic              rsp_valid,
    input  logic [DATA_W-1:0] rsp_rdata,
    output logic              rf_we,
    output logic [REG_W-1:0]  rf_wr_idx,
    output logic [DATA_W-1:0] rf_wr_data,
    output logic [REG_W-1:0]  rf_rd_idx,
    input  logic [DATA_W-1:0] rf_rd_data,
    output logic              xlat_req,
    output logic [ADDR_W-1:0] xlat_addr,
    input  logic              xlat_done,
    input  logic              xlat_fault
);
    typedef struct packed {
        state_e            st;
        logic              store;
        logic [REG_W-1:0]  first;
        logic [REG_W-1:0]  cur;
        logic [ADDR_W-1:0] addr;
        logic              pg_ok;
        logic              fault;
        logic [REG_W:0]    outst;
        logic              done;
        logic              exc;
        cause_e            cause;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [ADDR_W-1:0] ea;
    cause_e            chk_cause;
    logic              accept;
    logic              on_bound;
    logic              rsp_take;
    logic              fire;
    logic              last_reg;

    lsm_ea_check #(
        .ADDR_W   (ADDR_W),
        .DISP_W   (DISP_W),
        .REG_W    (REG_W),
        .LANE_BITS(LANE_BITS)
    ) u_ea (
        .op_store (op_store),
        .start_reg(start_reg),
        .base_idx (base_idx),
        .base_val (base_val),
        .disp     (disp),
        .le_mode  (le_mode),
        .ea       (ea),
        .cause    (chk_cause)
    );

    lsm_rsp_track #(
        .REG_W(REG_W)
    ) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .active   (busy),
        .is_load  (!ctl_q.store),
        .first_reg(ctl_q.first),
        .rsp_valid(rsp_valid),
        .wr_en    (rf_we),
        .wr_idx   (rf_wr_idx)
    );

    assign busy = (ctl_q.st != S_IDLE);

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.done = 1'b0;
        ctl_d.exc  = 1'b0;
        req_valid = 1'b0;
        xlat_req  = 1'b0;
        accept    = start && (ctl_q.st == S_IDLE);
        on_bound  = (ctl_q.cur != ctl_q.first) &&
                    (ctl_q.addr[PAGE_BITS-1:0] == '0) && !ctl_q.pg_ok;
        rsp_take  = rsp_valid && busy && !ctl_q.store;
        last_reg  = (ctl_q.cur == REG_W'(REG_N - 1));

        case (ctl_q.st)
            S_IDLE: begin
                if (accept) begin
                    if (chk_cause != CAUSE_NONE) begin
                        ctl_d.exc   = 1'b1;
                        ctl_d.cause = chk_cause;
                    end else begin
                        ctl_d.st    = S_ISSUE;
                        ctl_d.store = op_store;
                        ctl_d.first = start_reg;
                        ctl_d.cur   = start_reg;
                        ctl_d.addr  = ea;
                        ctl_d.pg_ok = 1'b0;
                        ctl_d.fault = 1'b0;
                    end
                end
            end
            S_ISSUE: begin
                if (on_bound) begin
                    ctl_d.st = S_XLAT;
                end else begin
                    req_valid = 1'b1;
                    if (req_ready) begin
                        ctl_d.cur  = ctl_q.cur + 1'b1;
                        ctl_d.addr = ctl_q.addr + ADDR_W'(WORD_B);
                        if (last_reg) begin
                            ctl_d.st = S_DRAIN;
                        end
                    end
                end
            end
            S_XLAT: begin
                xlat_req = 1'b1;
                if (xlat_done) begin
                    if (xlat_fault) begin
                        ctl_d.fault = 1'b1;
                        ctl_d.st    = S_DRAIN;
                    end else begin
                        ctl_d.pg_ok = 1'b1;
                        ctl_d.st    = S_ISSUE;
                    end
                end
            end
            S_DRAIN: begin
                if (ctl_q.outst == {{REG_W{1'b0}}, rsp_take}) begin
                    ctl_d.st = S_IDLE;
                    if (ctl_q.fault) begin
                        ctl_d.exc   = 1'b1;
                        ctl_d.cause = CAUSE_PAGE;
                    end else begin
                        ctl_d.done = 1'b1;
                    end
                end
            end
            default: ctl_d.st = S_IDLE;
        endcase

        fire = req_valid && req_ready;
        if (accept) begin
            ctl_d.outst = '0;
        end else begin
            ctl_d.outst = ctl_q.outst + {{REG_W{1'b0}}, (fire && !ctl_q.store)}
                                      - {{REG_W{1'b0}}, rsp_take};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: S_IDLE, cause: CAUSE_NONE, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign done       = ctl_q.done;
    assign exc        = ctl_q.exc;
    assign exc_cause  = ctl_q.cause;
    assign req_we     = ctl_q.store;
    assign req_addr   = ctl_q.addr;
    assign req_wdata  = rf_rd_data;
    assign rf_rd_idx  = ctl_q.cur;
    assign rf_wr_data = rsp_rdata;
    assign xlat_addr  = ctl_q.addr;
endmodule

// File: rtl/lsm_seq_chk.sv
module lsm_seq_chk #(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              exc,
    input logic [1:0]        exc_cause,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_we,
    input logic [ADDR_W-1:0] req_addr,
    input logic              xlat_req,
    input logic [ADDR_W-1:0] xlat_addr,
    input logic              rf_we
);
    AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_addr[1:0] == 2'b00)); // R2

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_we))); // R10

    AST_NO_REQ_IN_XLAT: assert property (@(posedge clk) disable iff (!rst_n)
        xlat_req |-> !req_valid); // R5

    AST_XLAT_PAGE_START: assert property (@(posedge clk) disable iff (!rst_n)
        xlat_req |-> (xlat_addr[PAGE_BITS-1:0] == '0)); // R5

    AST_END_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && exc)); // R9

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_EXC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        exc |=> !exc); // R9

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (done || exc) |-> !busy); // R9

    AST_EXC_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        exc |-> (exc_cause != 2'd0)); // R9

    AST_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid || xlat_req) |-> busy); // R9

    AST_RFWE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (busy && !req_we)); // R8
endmodule

bind lsm_seq lsm_seq_chk #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_chk (.*);

// File: tb/lsm_seq_tb.sv
module lsm_seq_tb;
    localparam int CLK_P = 10;
    localparam int WD_CYC = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, op_store = 1'b0, le_mode = 1'b0;
    logic [4:0]  start_reg = '0, base_idx = '0;
    logic [31:0] base_val = '0;
    logic [15:0] disp = '0;
    logic        busy, done, exc;
    logic [1:0]  exc_cause;
    logic        req_valid, req_we;
    logic        req_ready = 1'b0;
    logic [31:0] req_addr, req_wdata;
    logic        rsp_valid = 1'b0;
    logic [31:0] rsp_rdata = '0;
    logic        rf_we;
    logic [4:0]  rf_wr_idx, rf_rd_idx;
    logic [31:0] rf_wr_data, rf_rd_data;
    logic        xlat_req;
    logic [31:0] xlat_addr;
    logic        xlat_done = 1'b0, xlat_fault = 1'b0;

    logic [31:0] rf [32];
    assign rf_rd_data = rf[rf_rd_idx];

    lsm_seq u_dut (.*);

    always #(CLK_P/2) clk = ~clk;

    int n_run = 0, n_fail = 0;
    int cyc = 0;
    // monitor state
    logic        cfg_stall = 1'b0, cfg_fault = 1'b0, cfg_op = 1'b0;
    logic [31:0] cfg_ea = '0;
    logic [4:0]  cfg_s = '0;
    int          acc_cnt = 0, xlat_cnt = 0, mon_err = 0, end_cnt = 0;
    logic [1:0]  res_cause = '0;
    logic        pend = 1'b0, xd_next = 1'b0;
    logic [31:0] pend_d = '0;

    function automatic logic [31:0] init_val(int n);
        return 32'h1100_0000 + n;
    endfunction

    function automatic logic [31:0] mem_val(logic [31:0] a);
        return a ^ 32'hA5A5_0000;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // drive at the falling edge, sample shortly after
    always begin
        @(negedge clk);
        cyc++;
        req_ready  = !cfg_stall || cyc[0];
        rsp_valid  = pend;
        rsp_rdata  = pend_d;
        xlat_done  = xd_next;
        xlat_fault = cfg_fault;
        #(CLK_P/5);
        if (rf_we) rf[rf_wr_idx] = rf_wr_data;
        pend = 1'b0;
        if (req_valid && req_ready) begin
            if (req_addr !== cfg_ea + 32'(4 * acc_cnt) || req_we !== cfg_op) begin
                mon_err++;
                $display("mismatch access %0d addr %h we %b", acc_cnt, req_addr, req_we);
            end
            if (cfg_op && req_wdata !== init_val(int'(cfg_s) + acc_cnt)) begin
                mon_err++;
                $display("mismatch store data %h", req_wdata);
            end
            pend   = !req_we;
            pend_d = mem_val(req_addr);
            acc_cnt++;
        end
        xd_next = xlat_req && !xlat_done;
        if (xd_next) begin
            xlat_cnt++;
            if (xlat_addr[11:0] != 12'h000) mon_err++;
        end
        if (done) begin end_cnt++; res_cause = 2'd0; end
        if (exc)  begin end_cnt++; res_cause = exc_cause; end
    end

    task automatic run_op(input logic op, input logic [4:0] s, input logic [4:0] b,
                          input logic [31:0] bv, input logic [15:0] d, input logic le,
                          input logic flt, input logic stl, input logic [1:0] ecause,
                          input int tag, input bit poke, input bit keep_rf);
        logic [31:0] ea;
        int nw, acc, xl, bad;
        string rq;
        rq = $sformatf("R%0d", tag);
        ea = ((b == 5'd0) ? 32'd0 : bv) + {{16{d[15]}}, d};
        nw = 32 - int'(s);
        acc = nw; xl = 0;
        if (ecause == 2'd1 || ecause == 2'd2) acc = 0;
        else begin
            for (int k = 1; k < nw; k++) begin
                if ((ea + 32'(4 * k)) % 32'h1000 == 0 && xl == 0) begin
                    xl = 1;
                    if (flt) acc = k;
                end
            end
        end
        if (!keep_rf) for (int i = 0; i < 32; i++) rf[i] = init_val(i);
        @(negedge clk);
        cfg_op = op; cfg_s = s; cfg_ea = ea; cfg_fault = flt; cfg_stall = stl;
        acc_cnt = 0; xlat_cnt = 0; mon_err = 0; end_cnt = 0;
        start = 1'b1; op_store = op; start_reg = s; base_idx = b;
        base_val = bv; disp = d; le_mode = le;
        @(negedge clk);
        start = 1'b0;
        for (int t = 0; t < 3000 && end_cnt == 0; t++) begin
            @(negedge clk);
            if (poke && t == 3) begin
                start = 1'b1; op_store = !op; le_mode = 1'b1; start_reg = 5'd30;
            end else if (poke && t == 4) begin
                start = 1'b0; le_mode = 1'b0;
            end
        end
        start = 1'b0; le_mode = 1'b0;
        repeat (6) @(negedge clk);
        chk(end_cnt == 1, poke ? "R9" : rq, "end pulse count", end_cnt, 1);
        chk(res_cause == ecause, rq, "cause", res_cause, ecause);
        chk(acc_cnt == acc, rq, "access count", acc_cnt, acc);
        chk(xlat_cnt == xl, rq, "page checks", xlat_cnt, xl);
        chk(mon_err == 0, rq, "address/data order", mon_err, 0);
        bad = 0;
        for (int n = 0; n < 32; n++) begin
            int k;
            logic [31:0] e;
            k = n - int'(s);
            e = (!op && n >= int'(s) && k < acc) ? mem_val(ea + 32'(4 * k)) : init_val(n);
            if (rf[n] !== e) bad++;
        end
        chk(bad == 0, "R8", "register file contents", bad, 0);
        chk(busy == 1'b0, "R9", "idle after end", busy, 0);
    endtask

    typedef struct packed {
        logic        op;
        logic [4:0]  s;
        logic [4:0]  b;
        logic [31:0] bv;
        logic [15:0] d;
        logic        le;
        logic        flt;
        logic        stl;
        logic [1:0]  cause;
        logic [3:0]  tag;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 5'd28, 5'd3,  32'h0000_1000, 16'h0010, 1'b0, 1'b0, 1'b0, 2'd0, 4'd1}, // R1 plain load
        '{1'b1, 5'd20, 5'd5,  32'h0000_2000, 16'hFFF8, 1'b0, 1'b0, 1'b1, 2'd0, 4'd5}, // R5 store crossing, clean
        '{1'b0, 5'd24, 5'd2,  32'h0000_3FF0, 16'h0000, 1'b0, 1'b1, 1'b0, 2'd3, 4'd6}, // R6 load crossing, fault
        '{1'b1, 5'd16, 5'd7,  32'h0000_7FF0, 16'h0000, 1'b0, 1'b1, 1'b1, 2'd3, 4'd6}, // R6 store crossing, fault
        '{1'b1, 5'd4,  5'd6,  32'h0000_1002, 16'h0000, 1'b0, 1'b0, 1'b0, 2'd1, 4'd2}, // R2 misaligned base
        '{1'b0, 5'd8,  5'd6,  32'h0000_1000, 16'h0001, 1'b0, 1'b0, 1'b0, 2'd1, 4'd2}, // R2 misaligned disp
        '{1'b0, 5'd8,  5'd6,  32'h0000_1000, 16'h0000, 1'b1, 1'b0, 1'b0, 2'd1, 4'd3}, // R3 load in LE
        '{1'b1, 5'd8,  5'd6,  32'h0000_1000, 16'h0000, 1'b1, 1'b0, 1'b0, 2'd1, 4'd3}, // R3 store in LE
        '{1'b0, 5'd10, 5'd15, 32'h0000_1000, 16'h0000, 1'b0, 1'b0, 1'b0, 2'd2, 4'd4}, // R4 base in range
        '{1'b0, 5'd10, 5'd9,  32'h0000_4000, 16'h0020, 1'b0, 1'b0, 1'b0, 2'd0, 4'd4}, // R4 base just below
        '{1'b1, 5'd0,  5'd31, 32'h0000_5000, 16'h0100, 1'b0, 1'b0, 1'b1, 2'd0, 4'd4}, // R4 store never invalid
        '{1'b0, 5'd0,  5'd0,  32'hDEAD_0000, 16'h0100, 1'b0, 1'b0, 1'b0, 2'd0, 4'd1}, // R1 zero base
        '{1'b0, 5'd12, 5'd20, 32'h0000_1001, 16'h0000, 1'b0, 1'b0, 1'b0, 2'd1, 4'd4}, // R4 alignment wins
        '{1'b0, 5'd31, 5'd1,  32'h0000_6000, 16'h0000, 1'b0, 1'b0, 1'b0, 2'd0, 4'd5}, // R5 first word on page start
        '{1'b0, 5'd29, 5'd1,  32'h0000_6FF8, 16'h0000, 1'b0, 1'b0, 1'b1, 2'd0, 4'd10},// R10 stalled load crossing
        '{1'b0, 5'd26, 5'd1,  32'h0000_8000, 16'h8000, 1'b0, 1'b0, 1'b0, 2'd0, 4'd1}  // R1 sign-extended wrap
    };

    initial begin
        #(CLK_P * WD_CYC);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) rf[i] = init_val(i);
        repeat (3) @(negedge clk);
        #(CLK_P/5);
        // R9 reset state
        chk(!busy && !done && !exc && !req_valid && !xlat_req, "R9", "reset outputs",
            {busy, done, exc, req_valid, xlat_req}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            run_op(VECS[v].op, VECS[v].s, VECS[v].b, VECS[v].bv, VECS[v].d, VECS[v].le,
                   VECS[v].flt, VECS[v].stl, VECS[v].cause, int'(VECS[v].tag), 1'b0, 1'b0);
        end

        // R7 retry after a page fault restarts from the first register
        run_op(1'b0, 5'd24, 5'd2, 32'h0000_3FF0, 16'h0000, 1'b0, 1'b1, 1'b0, 2'd3, 6, 1'b0, 1'b0);
        run_op(1'b0, 5'd24, 5'd2, 32'h0000_3FF0, 16'h0000, 1'b0, 1'b0, 1'b0, 2'd0, 7, 1'b0, 1'b1);

        // R9 a start pulse while busy is ignored
        run_op(1'b0, 5'd0, 5'd0, 32'h0, 16'h0200, 1'b0, 1'b0, 1'b1, 2'd0, 9, 1'b1, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule